// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This execution unit serves a 32-bit processor pipeline. It recognises two immediate-form bit-field instructions and produces their results. The extract form selects a contiguous field from the source operand and returns it right-aligned, with every bit above it cleared. The insert form takes the low-order bits of the source operand and writes them into a field of the current destination value, keeping every other destination bit.

The decode stage supplies the instruction word, the source operand value, the current destination value and a valid strobe. One cycle later the unit presents the following:
- the result;
- the destination register index;
- a single-cycle write enable;
- an illegal-encoding flag for field descriptions that cannot be honoured.

Words that are not one of the two forms pass through without a write and without a flag.

Top module: `bitfield_unit`

## Requirements
- R1: While reset is asserted and after it is released, `res_we`, `res_illegal`, `res_data` and `res_rd` are zero until the first valid input.
- R2: A word is an extract when `(instr & 32'hFC00C000) == 32'h64004000`. Its width is `instr[10:6]` and its start offset is `instr[4:0]`. The result is `(src_val >> offset)` masked to `width` bits, and all higher bits are zero.
- R3: A word is an insert when `(instr & 32'hFC00C000) == 32'h64008000`. `instr[10:6]` holds the index of the field's top bit, and `instr[4:0]` holds the start offset. The field is bits offset through top. The result holds `src_val` bits `[top-offset:0]` in that field and `dst_val` bits everywhere else.
- R4: `res_rd` carries `instr[25:21]` of the last valid input.
- R5: The result, `res_rd` and `res_we` appear on the cycle after `in_valid`. `res_we` is high for exactly one cycle for each accepted legal word.
- R6: An extract with width zero raises `res_illegal` for one cycle and does not raise `res_we`.
- R7: An extract whose width plus offset exceeds 32 raises `res_illegal` and does not raise `res_we`. Width 31 at offset 1 is legal.
- R8: An insert whose top index is smaller than its offset raises `res_illegal` and does not raise `res_we`. A top index equal to the offset is a legal one-bit field.
- R9: A valid word that matches neither pattern gives neither `res_we` nor `res_illegal`. An example is `32'h64000400`.
- R10: An insert with offset 0 and top index 31 returns `src_val` unchanged (full-width field).
- R11: When `in_valid` is low, `res_we` and `res_illegal` are low on the next cycle, whatever the instruction word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| src_val | input | 32 | Source operand value |
| dst_val | input | 32 | Current destination register value |
| res_data | output | 32 | Registered result |
| res_rd | output | 5 | Destination register index |
| res_we | output | 1 | One-cycle write enable |
| res_illegal | output | 1 | One-cycle illegal field encoding flag |

## Verification
The bench builds two copies of the unit with the default 32-bit word and the default opcode patterns. The copy `uut` uses the per-bit comparator mask, and the copy `uut_shift` uses the two-shift mask. Because the two copies must agree on every word, both mask variants are exercised against the same field boundaries: offset 0, top index 31, one-bit fields, and extracts that end exactly at bit 31. Directed words cover each illegal boundary and a neighbouring barrel-shift encoding. Random words sweep offset and width across the whole legal triangle.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
   typedef enum logic [1:0] {
      BFU_NONE    = 2'd0,
      BFU_EXTRACT = 2'd1,
      BFU_INSERT  = 2'd2
   } bfu_kind_e;

   localparam int MASK_BY_COMPARE = 0;
   localparam int MASK_BY_SHIFT   = 1;
endpackage

// File: rtl/bfu_decode.sv
module bfu_decode #(
   parameter int INSTR_W = 32,
   parameter int DATA_W  = 32,
   parameter int IDX_W   = 5,
   parameter logic [INSTR_W-1:0] OP_MASK  = 32'hFC00C000,
   parameter logic [INSTR_W-1:0] EXT_CODE = 32'h64004000,
   parameter logic [INSTR_W-1:0] INS_CODE = 32'h64008000,
   parameter int RD_LSB  = 21,
   parameter int WID_LSB = 6,
   parameter int SH_LSB  = 0
) (
   input  logic [INSTR_W-1:0]         instr,
   output bfu_pkg::bfu_kind_e         kind,
   output logic [IDX_W-1:0]           rd,
   output logic [$clog2(DATA_W)-1:0]  lo_pos,
   output logic [$clog2(DATA_W)-1:0]  hi_pos,
   output logic                       bad_field
);
   localparam int POS_W = $clog2(DATA_W);
   localparam logic [POS_W:0] FULL = (POS_W+1)'(DATA_W);

   logic [INSTR_W-1:0] masked;
   logic [POS_W-1:0]   wfld;
   logic [POS_W:0]     ext_end;
   logic               ext_ok;
   logic               ins_ok;

   assign masked  = instr & OP_MASK;
   assign wfld    = instr[WID_LSB +: POS_W];
   assign lo_pos  = instr[SH_LSB +: POS_W];
   assign rd      = instr[RD_LSB +: IDX_W];
   assign ext_end = {1'b0, lo_pos} + {1'b0, wfld};
   assign ext_ok  = (wfld != '0) && (ext_end <= FULL);
   assign ins_ok  = (wfld >= lo_pos);

   always_comb begin
      kind      = bfu_pkg::BFU_NONE;
      hi_pos    = wfld;
      bad_field = 1'b0;
      if (masked == EXT_CODE) begin
         kind      = bfu_pkg::BFU_EXTRACT;
         hi_pos    = POS_W'(ext_end - (POS_W+1)'(1));
         bad_field = ~ext_ok;
      end else if (masked == INS_CODE) begin
         kind      = bfu_pkg::BFU_INSERT;
         hi_pos    = wfld;
         bad_field = ~ins_ok;
      end
   end
endmodule

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen #(
   parameter int DATA_W    = 32,
   parameter int MASK_IMPL = bfu_pkg::MASK_BY_COMPARE
) (
   input  logic [$clog2(DATA_W)-1:0] lo_pos,
   input  logic [$clog2(DATA_W)-1:0] hi_pos,
   output logic [DATA_W-1:0]         mask
);
   localparam int POS_W = $clog2(DATA_W);
   localparam logic [DATA_W-1:0] ONES = '1;
   localparam logic [POS_W-1:0]  TOP  = POS_W'(DATA_W-1);

   generate
      if (MASK_IMPL == bfu_pkg::MASK_BY_COMPARE) begin : g_cmp
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            localparam logic [POS_W-1:0] IDX = POS_W'(i);
            assign mask[i] = (IDX >= lo_pos) && (IDX <= hi_pos);
         end
      end else begin : g_shf
         // Both shift amounts stay within 0..DATA_W-1.
         assign mask = (ONES >> (TOP - hi_pos)) & (ONES << lo_pos);
      end
   endgenerate
endmodule

// File: rtl/bfu_merge.sv
module bfu_merge #(
   parameter int DATA_W = 32
) (
   input  bfu_pkg::bfu_kind_e         kind,
   input  logic [DATA_W-1:0]          src_val,
   input  logic [DATA_W-1:0]          dst_val,
   input  logic [DATA_W-1:0]          mask,
   input  logic [$clog2(DATA_W)-1:0]  lo_pos,
   output logic [DATA_W-1:0]          result
);
   logic [DATA_W-1:0] ext_res;
   logic [DATA_W-1:0] ins_res;

   assign ext_res = (src_val & mask) >> lo_pos;
   assign ins_res = (dst_val & ~mask) | ((src_val << lo_pos) & mask);
   assign result  = (kind == bfu_pkg::BFU_EXTRACT) ? ext_res : ins_res;
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
   parameter int INSTR_W   = 32,
   parameter int DATA_W    = 32,
   parameter int IDX_W     = 5,
   parameter logic [INSTR_W-1:0] OP_MASK  = 32'hFC00C000,
   parameter logic [INSTR_W-1:0] EXT_CODE = 32'h64004000,
   parameter logic [INSTR_W-1:0] INS_CODE = 32'h64008000,
   parameter int RD_LSB    = 21,
   parameter int WID_LSB   = 6,
   parameter int SH_LSB    = 0,
   parameter int MASK_IMPL = bfu_pkg::MASK_BY_COMPARE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [31:0]        instr,
   input  logic [31:0]        src_val,
   input  logic [31:0]        dst_val,
   output logic [31:0]        res_data,
   output logic [4:0]         res_rd,
   output logic               res_we,
   output logic               res_illegal
);
   localparam int POS_W = $clog2(DATA_W);

   generate
      if (INSTR_W != 32 || DATA_W != 32 || IDX_W != 5) begin : g_bad_width
         initial $error("bitfield_unit: port widths are fixed at 32/32/5");
      end
      if ((DATA_W & (DATA_W - 1)) != 0) begin : g_bad_pow2
         initial $error("bitfield_unit: DATA_W must be a power of two");
      end
      if (RD_LSB + IDX_W > INSTR_W || WID_LSB + POS_W > INSTR_W
          || SH_LSB + POS_W > INSTR_W) begin : g_bad_field
         initial $error("bitfield_unit: a field lies outside the word");
      end
      if (((EXT_CODE | INS_CODE) & ~OP_MASK) != '0 || EXT_CODE == INS_CODE) begin : g_bad_code
         initial $error("bitfield_unit: opcode patterns inconsistent with mask");
      end
      if (MASK_IMPL != bfu_pkg::MASK_BY_COMPARE
          && MASK_IMPL != bfu_pkg::MASK_BY_SHIFT) begin : g_bad_impl
         initial $error("bitfield_unit: unknown MASK_IMPL");
      end
   endgenerate

   bfu_pkg::bfu_kind_e kind;
   logic [IDX_W-1:0]   rd;
   logic [POS_W-1:0]   lo_pos;
   logic [POS_W-1:0]   hi_pos;
   logic               bad_field;
   logic [DATA_W-1:0]  mask;
   logic [DATA_W-1:0]  result;
   logic               recognised;

   bfu_decode #(
      .INSTR_W(INSTR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
      .OP_MASK(OP_MASK), .EXT_CODE(EXT_CODE), .INS_CODE(INS_CODE),
      .RD_LSB(RD_LSB), .WID_LSB(WID_LSB), .SH_LSB(SH_LSB)
   ) u_decode (
      .instr(instr), .kind(kind), .rd(rd),
      .lo_pos(lo_pos), .hi_pos(hi_pos), .bad_field(bad_field)
   );

   bfu_mask_gen #(.DATA_W(DATA_W), .MASK_IMPL(MASK_IMPL)) u_mask (
      .lo_pos(lo_pos), .hi_pos(hi_pos), .mask(mask)
   );

   bfu_merge #(.DATA_W(DATA_W)) u_merge (
      .kind(kind), .src_val(src_val), .dst_val(dst_val),
      .mask(mask), .lo_pos(lo_pos), .result(result)
   );

   assign recognised = (kind != bfu_pkg::BFU_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_we      <= 1'b0;
         res_illegal <= 1'b0;
         res_data    <= '0;
         res_rd      <= '0;
      end else begin
         res_we      <= in_valid & recognised & ~bad_field;
         res_illegal <= in_valid & recognised & bad_field;
         if (in_valid) begin
            res_data <= result;
            res_rd   <= rd;
         end
      end
   end
endmodule

// File: rtl/bfu_checker.sv
module bfu_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [31:0] instr,
   input logic [31:0] src_val,
   input logic [31:0] dst_val,
   input logic [31:0] res_data,
   input logic [4:0]  res_rd,
   input logic        res_we,
   input logic        res_illegal
);
   logic        is_ext, is_ins, ext_ok, ins_ok;
   logic [4:0]  w5, s5;
   logic [63:0] ins_mask64;

   assign is_ext = (instr & 32'hFC00C000) == 32'h64004000;
   assign is_ins = (instr & 32'hFC00C000) == 32'h64008000;
   assign w5     = instr[10:6];
   assign s5     = instr[4:0];
   assign ext_ok = (w5 != 5'd0) && ({1'b0, w5} + {1'b0, s5} <= 6'd32);
   assign ins_ok = (w5 >= s5);
   assign ins_mask64 = ((64'd1 << ({1'b0, w5} - {1'b0, s5} + 6'd1)) - 64'd1) << s5;

   assert_we_ill_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_we && res_illegal));

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!res_we && !res_illegal));

   assert_nomatch_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !is_ext && !is_ins) |=> (!res_we && !res_illegal));

   assert_ext_zero_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_ext && w5 == 5'd0) |=> (res_illegal && !res_we));

   assert_ext_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_ext && w5 != 5'd0 && !ext_ok) |=> (res_illegal && !res_we));

   assert_ins_inverted_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_ins && !ins_ok) |=> (res_illegal && !res_we));

   assert_ext_zero_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_ext && ext_ok) |=>
         (res_we && ((res_data >> $past(w5)) == 32'd0)));

   assert_ins_keeps_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_ins && ins_ok) |=>
         (res_we && (((res_data ^ $past(dst_val)) & ~$past(ins_mask64[31:0])) == 32'd0)));

   assert_rd_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (res_rd == $past(instr[25:21])));

   always_comb begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (!res_we && !res_illegal);
      end
   end
endmodule

bind bitfield_unit bfu_checker u_bfu_checker (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
   .src_val(src_val), .dst_val(dst_val), .res_data(res_data),
   .res_rd(res_rd), .res_we(res_we), .res_illegal(res_illegal)
);

// File: tb/bitfield_unit_test.sv
module bitfield_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] instr = '0, src_val = '0, dst_val = '0;
   logic [31:0] res_data, res_data_s;
   logic [4:0]  res_rd, res_rd_s;
   logic        res_we, res_we_s, res_illegal, res_illegal_s;
   int          n_tests = 0;
   int          n_fail = 0;

   always #5 clk = ~clk;

   bitfield_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .src_val(src_val), .dst_val(dst_val), .res_data(res_data),
      .res_rd(res_rd), .res_we(res_we), .res_illegal(res_illegal));

   bitfield_unit #(.MASK_IMPL(1)) uut_shift (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .src_val(src_val), .dst_val(dst_val), .res_data(res_data_s),
      .res_rd(res_rd_s), .res_we(res_we_s), .res_illegal(res_illegal_s));

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input bit ins, input logic [4:0] rd,
                                      input logic [4:0] wf, input logic [4:0] sh);
      return (ins ? 32'h64008000 : 32'h64004000) | {6'd0, rd, 21'd0}
             | {21'd0, wf, 6'd0} | {27'd0, sh};
   endfunction

   // Reference model: write enable, illegal flag, data.
   function automatic logic [33:0] model(input logic [31:0] iw, input logic [31:0] s,
                                         input logic [31:0] d);
      logic [31:0] masked = iw & 32'hFC00C000;
      int w = int'(iw[10:6]);
      int sh = int'(iw[4:0]);
      logic [63:0] m;
      logic [63:0] r;
      if (masked == 32'h64004000) begin
         if (w == 0 || w + sh > 32) return {2'b01, 32'd0};
         r = ({32'd0, s} >> sh) & ((64'd1 << w) - 64'd1);
         return {2'b10, r[31:0]};
      end else if (masked == 32'h64008000) begin
         if (w < sh) return {2'b01, 32'd0};
         m = ((64'd1 << (w - sh + 1)) - 64'd1) << sh;
         r = ({32'd0, d} & ~m) | (({32'd0, s} << sh) & m);
         return {2'b10, r[31:0]};
      end
      return {2'b00, 32'd0};
   endfunction

   task automatic run_op(input logic [31:0] iw, input logic [31:0] s,
                         input logic [31:0] d, input string tag);
      logic [33:0] e;
      in_valid = 1'b1; instr = iw; src_val = s; dst_val = d;
      e = model(iw, s, d);
      @(negedge clk);
      check(res_we == e[33], {tag, " we"}, {31'd0, res_we}, {31'd0, e[33]});
      check(res_illegal == e[32], {tag, " illegal"}, {31'd0, res_illegal}, {31'd0, e[32]});
      check(res_rd == iw[25:21], "R4 rd", {27'd0, res_rd}, {27'd0, iw[25:21]});
      if (e[33]) begin
         check(res_data == e[31:0], {tag, " data"}, res_data, e[31:0]);
         check(res_data_s == e[31:0], {tag, " data shift-mask"}, res_data_s, e[31:0]);
      end
      check(res_we_s == res_we && res_illegal_s == res_illegal, {tag, " variants agree"},
            {30'd0, res_we_s, res_illegal_s}, {30'd0, res_we, res_illegal});
      in_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] iw;
      void'($urandom(32'd7741));
      repeat (3) @(negedge clk);
      check(!res_we && !res_illegal && res_data == 0 && res_rd == 0, "R1 in reset",
            {res_we, res_illegal, res_data[29:0]}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!res_we && !res_illegal && res_data == 0, "R1 after release",
            {res_we, res_illegal, res_data[29:0]}, 32'd0);

      // Directed corners
      run_op(mk(0, 5'd3, 5'd8, 5'd4), 32'hDEADBEEF, 32'h0, "R2 extract byte");
      run_op(mk(0, 5'd7, 5'd31, 5'd1), 32'hFFFF_FFFF, 32'h0, "R7 extract ends at 31");
      run_op(mk(0, 5'd7, 5'd31, 5'd2), 32'h1234_5678, 32'h0, "R7 extract overrun");
      run_op(mk(0, 5'd9, 5'd0, 5'd5), 32'h1234_5678, 32'h0, "R6 extract width zero");
      run_op(32'h65005f5f, 32'hA5A5_A5A5, 32'h0, "R7 extract 29 at 31");
      run_op(mk(1, 5'd2, 5'd31, 5'd0), 32'hCAFE_F00D, 32'h1111_1111, "R10 full insert");
      run_op(mk(1, 5'd2, 5'd3, 5'd5), 32'hFFFF_FFFF, 32'h1234_5678, "R8 insert inverted");
      run_op(mk(1, 5'd4, 5'd9, 5'd9), 32'hFFFF_FFFF, 32'h0, "R8 insert one bit");
      run_op(mk(1, 5'd1, 5'd15, 5'd8), 32'h0000_00AB, 32'hFFFF_FFFF, "R3 insert mid byte");
      run_op(32'h64000400, 32'h1, 32'h2, "R9 neighbour shift word");
      run_op(32'h0, 32'h1, 32'h2, "R9 zero word");

      // R11: matching word with valid low
      instr = mk(0, 5'd6, 5'd4, 5'd0); src_val = 32'hF; in_valid = 1'b0;
      @(negedge clk);
      check(!res_we && !res_illegal, "R11 valid low", {30'd0, res_we, res_illegal}, 32'd0);
      // R5: single-cycle strobe
      run_op(mk(0, 5'd6, 5'd4, 5'd0), 32'hF, 32'h0, "R5 strobe");
      @(negedge clk);
      check(!res_we, "R5 we drops after one cycle", {31'd0, res_we}, 32'd0);

      // Constrained random
      for (int k = 0; k < 400; k++) begin
         int sel = int'($urandom % 4);
         logic [4:0] rd = 5'($urandom);
         int sh = int'($urandom % 32);
         int wd;
         case (sel)
            0: begin
               wd = 1 + int'($urandom % 32'(32 - sh));
               if (wd > 31) wd = 31;
               iw = mk(0, rd, 5'(wd), 5'(sh));
            end
            1: iw = mk(1, rd, 5'(sh + int'($urandom % 32'(32 - sh))), 5'(sh));
            2: iw = mk($urandom % 2 == 0, rd, 5'($urandom), 5'($urandom));
            default: iw = $urandom;
         endcase
         run_op(iw, $urandom, $urandom,
                sel == 1 ? "R3 random insert" : sel == 0 ? "R2 random extract"
                         : "R6 R7 R8 R9 random word");
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule